// File: doc/BRIEF.md
# Command-Driven Packet Interface

This block gives a processor a simple way to move whole packets through a memory-mapped window. A shared byte buffer holds the packet being sent or the packet just received. A length register and a command register start the transfer. A two-bit status word reports what the last receive command did and drives one interrupt line.

A send command streams the first `length` buffer bytes out of a byte-wide transmit port, one byte per cycle, with start and last markers. Incoming packets arrive on a byte-wide input with valid and last. They wait in a small store that holds a few packets. Nothing enters the buffer until software asks for it: each receive command copies the oldest waiting packet into the buffer from address zero. It then records the packet length and sets the status bits. Reading the status word returns it, clears it and drops the interrupt.

Top module: `pktif_top`

## Requirements
- R1: After reset, `irq` and `tx_valid` are low, and a read of the status (0x4000), length (0x4010) and busy (0x4030) registers returns 0.
- R2: Bus addresses below `BUF_BYTES` read and write one buffer byte in bits 7:0, with read data on `bus_rdata` one cycle after `bus_rd`. Other addresses from `BUF_BYTES` to 0x3FFF read as 0, and writes to them are dropped.
- R3: Writing 0x0001 to the command register (0x4020) emits buffer bytes 0 to L-1 on the transmit port, one per cycle and without gaps, where L is the send length. `tx_sop` marks the first byte and `tx_eop` the last. A length written to 0x4010 that exceeds `BUF_BYTES` is clamped to `BUF_BYTES`.
- R4: A send command with length 0 emits no byte and leaves busy clear.
- R5: The receive store keeps up to `STORE_PKTS` (default 4) packets in arrival order. A packet whose first byte arrives while the store is full is dropped whole.
- R6: Writing 0x0000 to the command register while a packet waits copies that packet into buffer bytes 0 onward. The read length becomes its byte count. Status bit 0 is set to 1, and status bit 1 is set to 1 if another packet still waits, else 0.
- R7: A receive command with no packet waiting sets the status to 0 and the read length to 0.
- R8: `irq` is high exactly when the status is non-zero. A status read returns the value and clears it, so `irq` is low in the next cycle.
- R9: Register 0x4030 bit 0 reads 1 while a send or a receive copy is in progress. Any command written then is ignored.
- R10: Command values other than 0x0000 and 0x0001 have no effect.
- R11: A received packet longer than `BUF_BYTES` keeps only its first `BUF_BYTES` bytes and reports length `BUF_BYTES`.
- R12: A packet that would not fit in the store's remaining byte space (`STORE_BYTES`) is dropped whole, and packets already stored are not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 16 | Byte address in the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after `bus_rd` |
| irq | output | 1 | High while the status is non-zero |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_sop | output | 1 | First byte of a sent packet |
| tx_eop | output | 1 | Last byte of a sent packet |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Last byte of a received packet |

## Verification
Some properties are checked on every cycle by the assertions:
- a sent stream has no gaps;
- a stream starts with the start marker;
- the port is quiet while idle;
- `irq` is low after a status read or an empty receive;
- the store's packet and byte counts stay within their bounds.

Other behaviour only shows up in the bench's scenarios, which compare against a behavioural model of the buffer and the store:
- bytes are copied in the right order;
- the more-waiting bit is correct;
- oversize packets are dropped or truncated;
- commands written while busy or with unknown values are ignored.

// File: rtl/pktif_pkg.sv
// Shared constants for the packet interface.
// Register offsets and command codes are fixed because software decodes them.
package pktif_pkg;
    localparam logic [15:0] ADDR_STATUS = 16'h4000;
    localparam logic [15:0] ADDR_LENGTH = 16'h4010;
    localparam logic [15:0] ADDR_CMD    = 16'h4020;
    localparam logic [15:0] ADDR_BUSY   = 16'h4030;

    localparam logic [15:0] CMD_RECV = 16'h0000;
    localparam logic [15:0] CMD_SEND = 16'h0001;

    // Source of the registered read data
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_BUF  = 2'd1,
        RSEL_REG  = 2'd2
    } rsel_t;
endpackage

// File: rtl/pktif_buf_ram.sv
// Packet buffer: one write port and one registered read port.
// Assumes the caller arbitrates both ports. The contents are not reset.
module pktif_buf_ram #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Write one byte when requested
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read one byte per cycle, registered
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/pktif_tx_seq.sv
// Transmit sequencer: emits buffer bytes 0..len-1 on consecutive cycles.
// Assumes the buffer read port follows rd_addr while active, with one cycle of latency.
module pktif_tx_seq #(
    parameter int BUF_BYTES = 2048,
    localparam int AW = $clog2(BUF_BYTES),
    localparam int LW = $clog2(BUF_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] len,
    input  logic [7:0]    ram_q,
    output logic          active,
    output logic [AW-1:0] rd_addr,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_sop,
    output logic          tx_eop,
    output logic          done
);
    logic          act;
    logic [LW-1:0] idx;
    logic [LW-1:0] nlen;
    logic          v_q, s_q, e_q;
    logic          at_end;

    assign at_end = (idx == nlen - LW'(1));

    // Step the read index and stop after the last byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act  <= 1'b0;
            idx  <= '0;
            nlen <= '0;
        end else if (start && !act && len != '0) begin
            act  <= 1'b1;
            idx  <= '0;
            nlen <= len;
        end else if (act) begin
            if (at_end) act <= 1'b0;
            idx <= idx + LW'(1);
        end
    end

    // Line the markers up with the registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= 1'b0;
            s_q <= 1'b0;
            e_q <= 1'b0;
        end else begin
            v_q <= act;
            s_q <= act && (idx == '0);
            e_q <= act && at_end;
        end
    end

    assign active   = act;
    assign rd_addr  = idx[AW-1:0];
    assign tx_valid = v_q;
    assign tx_data  = v_q ? ram_q : 8'h00;
    assign tx_sop   = s_q;
    assign tx_eop   = e_q;
    assign done     = v_q && e_q;

    // R3: a packet stream has no gaps
    assert_tx_no_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_eop) |=> tx_valid);
    // R3: every stream opens with the start marker
    assert_tx_starts_sop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> tx_sop);
endmodule

// File: rtl/pktif_rx_store.sv
// Receive store: queues whole packets from a byte stream and copies one out on request.
// Assumes STORE_BYTES and STORE_PKTS are powers of two and STORE_PKTS >= 2.
// Assumes pop is only raised when avail is high and no copy is running.
module pktif_rx_store #(
    parameter int BUF_BYTES   = 2048,
    parameter int STORE_BYTES = 2048,
    parameter int STORE_PKTS  = 4,
    localparam int AW  = $clog2(BUF_BYTES),
    localparam int LW  = $clog2(BUF_BYTES + 1),
    localparam int SAW = $clog2(STORE_BYTES),
    localparam int OCW = $clog2(STORE_BYTES + 1),
    localparam int PW  = $clog2(STORE_PKTS + 1),
    localparam int QAW = $clog2(STORE_PKTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic          pop,
    output logic          avail,
    output logic          cp_we,
    output logic [AW-1:0] cp_addr,
    output logic [7:0]    cp_data,
    output logic          done,
    output logic [LW-1:0] done_len,
    output logic          done_more
);
    logic [7:0]     store_mem [STORE_BYTES];
    logic [LW-1:0]  len_fifo  [STORE_PKTS];

    logic           in_pkt, drop_r;
    logic [LW-1:0]  cur_len;
    logic [SAW-1:0] wr_base;
    logic [OCW-1:0] occ;
    logic [PW-1:0]  pcnt;
    logic [QAW-1:0] lf_wr, lf_rd;

    logic           first, drop_now, under_cap, room, wr_byte, ovf, commit, take;
    logic [LW-1:0]  len_eff, commit_len;
    logic [31:0]    fill_w;

    logic           cp_act;
    logic [LW-1:0]  cp_len, cp_idx;
    logic [SAW-1:0] rd_ptr;
    logic           q_v, q_last;
    logic [AW-1:0]  q_idx;
    logic [7:0]     rd_q;

    // Decide per incoming byte whether to keep it, drop the packet or commit it
    always_comb begin
        first      = !in_pkt;
        len_eff    = first ? '0 : cur_len;
        drop_now   = first ? (pcnt == PW'(STORE_PKTS)) : drop_r;
        fill_w     = 32'(occ) + 32'(len_eff);
        room       = fill_w < 32'(STORE_BYTES);
        under_cap  = len_eff < LW'(BUF_BYTES);
        wr_byte    = rx_valid && !drop_now && under_cap && room;
        ovf        = rx_valid && !drop_now && under_cap && !room;
        commit     = rx_valid && rx_last && !drop_now && !ovf;
        commit_len = len_eff + LW'(wr_byte);
        take       = pop && (pcnt != '0) && !cp_act;
    end

    // Store a kept byte after the last committed packet
    always_ff @(posedge clk) begin
        if (wr_byte) store_mem[wr_base + SAW'(len_eff)] <= rx_data;
    end

    // Record the length of each committed packet
    always_ff @(posedge clk) begin
        if (commit) len_fifo[lf_wr] <= commit_len;
    end

    // Track the packet being received
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt  <= 1'b0;
            drop_r  <= 1'b0;
            cur_len <= '0;
        end else if (rx_valid) begin
            in_pkt  <= !rx_last;
            drop_r  <= rx_last ? 1'b0 : (drop_now || ovf);
            cur_len <= wr_byte ? len_eff + LW'(1) : len_eff;
        end
    end

    // Keep the committed write base, occupancy and packet count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_base <= '0;
            lf_wr   <= '0;
            occ     <= '0;
            pcnt    <= '0;
        end else begin
            if (commit) begin
                wr_base <= wr_base + SAW'(commit_len);
                lf_wr   <= lf_wr + QAW'(1);
            end
            occ  <= occ + (commit ? OCW'(commit_len) : '0) - OCW'(cp_act);
            pcnt <= pcnt + PW'(commit) - PW'(take);
        end
    end

    // Run the copy of one packet out of the store, one byte per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cp_act <= 1'b0;
            cp_len <= '0;
            cp_idx <= '0;
            rd_ptr <= '0;
            lf_rd  <= '0;
        end else if (take) begin
            cp_act <= 1'b1;
            cp_len <= len_fifo[lf_rd];
            cp_idx <= '0;
            lf_rd  <= lf_rd + QAW'(1);
        end else if (cp_act) begin
            if (cp_idx == cp_len - LW'(1)) cp_act <= 1'b0;
            cp_idx <= cp_idx + LW'(1);
            rd_ptr <= rd_ptr + SAW'(1);
        end
    end

    // Read the store every cycle at the copy pointer
    always_ff @(posedge clk) begin
        rd_q <= store_mem[rd_ptr];
    end

    // Line the copy address and markers up with the read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_v    <= 1'b0;
            q_last <= 1'b0;
            q_idx  <= '0;
        end else begin
            q_v    <= cp_act;
            q_last <= cp_act && (cp_idx == cp_len - LW'(1));
            q_idx  <= cp_idx[AW-1:0];
        end
    end

    assign avail     = (pcnt != '0);
    assign cp_we     = q_v;
    assign cp_addr   = q_idx;
    assign cp_data   = rd_q;
    assign done      = q_v && q_last;
    assign done_len  = cp_len;
    assign done_more = (pcnt != '0);

    // R5: never more packets than slots
    assert_pkt_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= PW'(STORE_PKTS));
    // R12: stored bytes never exceed the store
    assert_occ_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCW'(STORE_BYTES));
    // R11: a delivered packet is never empty or longer than the buffer
    assert_copy_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_len != '0 && done_len <= LW'(BUF_BYTES)));
endmodule

// File: rtl/pktif_top.sv
// Packet interface top: register decode, buffer arbitration, status and interrupt.
// Assumes software does not read the buffer while busy. Buffer writes from the bus
// are dropped while busy.
module pktif_top #(
    parameter int BUF_BYTES   = 2048,
    parameter int STORE_BYTES = 2048,
    parameter int STORE_PKTS  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        irq,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_sop,
    output logic        tx_eop,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last
);
    import pktif_pkg::*;

    localparam int AW = $clog2(BUF_BYTES);
    localparam int LW = $clog2(BUF_BYTES + 1);

    logic          in_buf, hit_stat, hit_len, hit_cmd, hit_busy, hit_reg;
    logic [AW-1:0] buf_idx;
    logic          cmd_wr, tx_go, rx_go, rx_empty;
    logic          busy_r;
    logic [1:0]    status;
    logic [LW-1:0] rx_len, tx_len;
    rsel_t         rsel;
    logic [15:0]   reg_q;

    logic          tx_act, tx_done;
    logic [AW-1:0] tx_addr;
    logic          avail, cp_we, rx_done, rx_more;
    logic [AW-1:0] cp_addr;
    logic [7:0]    cp_data, ram_q;
    logic [LW-1:0] rx_done_len;
    logic          ram_we;
    logic [AW-1:0] ram_waddr, ram_raddr;
    logic [7:0]    ram_wdata;

    // Decode the bus address and the accepted commands
    always_comb begin
        in_buf   = bus_addr < 16'(BUF_BYTES);
        buf_idx  = bus_addr[AW-1:0];
        hit_stat = bus_addr == ADDR_STATUS;
        hit_len  = bus_addr == ADDR_LENGTH;
        hit_cmd  = bus_addr == ADDR_CMD;
        hit_busy = bus_addr == ADDR_BUSY;
        hit_reg  = hit_stat || hit_len || hit_busy;
        cmd_wr   = bus_wr && hit_cmd && !busy_r;
        tx_go    = cmd_wr && bus_wdata == CMD_SEND && tx_len != '0;
        rx_go    = cmd_wr && bus_wdata == CMD_RECV && avail;
        rx_empty = cmd_wr && bus_wdata == CMD_RECV && !avail;
    end

    // Hold busy from an accepted command to the end of its transfer
    always_ff @(posedge clk) begin
        if (!rst_n)                busy_r <= 1'b0;
        else if (tx_go || rx_go)   busy_r <= 1'b1;
        else if (tx_done || rx_done) busy_r <= 1'b0;
    end

    // Update the status on receive results; a status read clears it
    always_ff @(posedge clk) begin
        if (!rst_n)                    status <= 2'b00;
        else if (rx_done)              status <= {rx_more, 1'b1};
        else if (rx_empty)             status <= 2'b00;
        else if (bus_rd && hit_stat)   status <= 2'b00;
    end

    // Keep the received length
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_len <= '0;
        else if (rx_done)  rx_len <= rx_done_len;
        else if (rx_empty) rx_len <= '0;
    end

    // Keep the send length, clamped to the buffer size
    always_ff @(posedge clk) begin
        if (!rst_n) tx_len <= '0;
        else if (bus_wr && hit_len)
            tx_len <= (bus_wdata > 16'(BUF_BYTES)) ? LW'(BUF_BYTES) : bus_wdata[LW-1:0];
    end

    // Register the read source and the register value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsel  <= RSEL_NONE;
            reg_q <= '0;
        end else begin
            rsel  <= !bus_rd ? RSEL_NONE : in_buf ? RSEL_BUF : hit_reg ? RSEL_REG : RSEL_NONE;
            reg_q <= hit_stat ? {14'b0, status} :
                     hit_len  ? 16'(rx_len) :
                     hit_busy ? {15'b0, busy_r} : 16'h0000;
        end
    end

    // Arbitrate the buffer ports between the bus and the sequencers
    always_comb begin
        ram_we    = busy_r ? cp_we : (bus_wr && in_buf);
        ram_waddr = busy_r ? cp_addr : buf_idx;
        ram_wdata = busy_r ? cp_data : bus_wdata[7:0];
        ram_raddr = tx_act ? tx_addr : buf_idx;
    end

    assign bus_rdata = (rsel == RSEL_BUF) ? {8'h00, ram_q} :
                       (rsel == RSEL_REG) ? reg_q : 16'h0000;
    assign irq = |status;

    pktif_buf_ram #(.DEPTH(BUF_BYTES)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr(ram_raddr), .rdata(ram_q)
    );

    pktif_tx_seq #(.BUF_BYTES(BUF_BYTES)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_go), .len(tx_len), .ram_q(ram_q),
        .active(tx_act), .rd_addr(tx_addr), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_sop(tx_sop), .tx_eop(tx_eop), .done(tx_done)
    );

    pktif_rx_store #(.BUF_BYTES(BUF_BYTES), .STORE_BYTES(STORE_BYTES),
                     .STORE_PKTS(STORE_PKTS)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .pop(rx_go), .avail(avail), .cp_we(cp_we),
        .cp_addr(cp_addr), .cp_data(cp_data), .done(rx_done),
        .done_len(rx_done_len), .done_more(rx_more)
    );

    // R8: a status read drops the interrupt in the next cycle
    assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_stat && !rx_done) |=> !irq);
    // R7: an empty receive leaves the interrupt low
    assert_empty_recv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |=> !irq);
    // R9: the transmit port stays quiet while idle
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_r |-> !tx_valid);
    // R9: the two sequencers never run together
    assert_one_transfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_act && cp_we));
endmodule

// File: tb/pktif_top_tb.sv
// Bench for pktif_top: behavioural model of the buffer and store, stream monitor.
module pktif_top_tb;
    localparam int BUF = 2048;
    localparam int SB  = 2048;
    localparam int NP  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_addr = '0, bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, tx_valid, tx_sop, tx_eop;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic [7:0] buf_m [BUF];
    logic [7:0] st_bytes [$];
    int         st_lens [$];
    int         st_occ = 0;

    logic [7:0] exp_tx [$];
    int tx_seen = 0, tx_bad = 0, tx_pos = 0;

    always #4 clk = ~clk;

    pktif_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop),
        .tx_eop(tx_eop), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] b;
        for (int i = 0; i < 5000; i++) begin
            rd(16'h4030, b);
            if (b == 16'h0000) break;
        end
        repeat (3) @(negedge clk);
    endtask

    // Feed one packet; the model keeps it if a slot and byte space remain
    task automatic rx_pkt(input int n, input int base);
        int keep;
        keep = (n > BUF) ? BUF : n;
        if (st_lens.size() < NP && st_occ + keep <= SB) begin
            for (int i = 0; i < keep; i++) st_bytes.push_back(8'((base + i) & 255));
            st_lens.push_back(keep);
            st_occ += keep;
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'((base + i) & 255); rx_last = (i == n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    // Issue a send and load the expected stream from the buffer model
    task automatic send(input int len_reg);
        exp_tx.delete();
        tx_seen = 0; tx_bad = 0; tx_pos = 0;
        for (int i = 0; i < len_reg; i++) exp_tx.push_back(buf_m[i]);
        wr(16'h4020, 16'h0001);
    endtask

    // Receive command with the model applied; returns expected status and length
    task automatic recv(output int est, output int elen);
        if (st_lens.size() == 0) begin
            est = 0; elen = 0;
        end else begin
            elen = st_lens.pop_front();
            st_occ -= elen;
            for (int i = 0; i < elen; i++) buf_m[i] = st_bytes.pop_front();
            est = 1 + ((st_lens.size() != 0) ? 2 : 0);
        end
        wr(16'h4020, 16'h0000);
        wait_idle();
    endtask

    // Stream monitor, compared on every clock
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            tx_seen++;
            if (exp_tx.size() == 0) tx_bad++;
            else begin
                if (tx_data != exp_tx.pop_front()) tx_bad++;
                if (tx_sop != (tx_pos == 0)) tx_bad++;
                if (tx_eop != (exp_tx.size() == 0)) tx_bad++;
            end
            tx_pos++;
        end else if (rst_n && tx_pos > 0 && exp_tx.size() != 0) begin
            tx_bad++;
        end
    end

    initial begin
        #(8 * 190000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int est, elen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(irq == 1'b0, "R1 irq", int'(irq), 0);
        check(tx_valid == 1'b0, "R1 tx_valid", int'(tx_valid), 0);
        rd(16'h4000, d); check(d == 0, "R1 status", int'(d), 0);
        rd(16'h4010, d); check(d == 0, "R1 length", int'(d), 0);
        rd(16'h4030, d); check(d == 0, "R1 busy", int'(d), 0);

        // R2: fill the whole buffer, read back, check out-of-range addresses
        for (int i = 0; i < BUF; i++) begin
            buf_m[i] = 8'((i * 7 + 3) & 255);
            wr(16'(i), {8'h00, buf_m[i]});
        end
        rd(16'd0, d); check(d == {8'h00, buf_m[0]}, "R2 read 0", int'(d), int'(buf_m[0]));
        rd(16'd1234, d); check(d == {8'h00, buf_m[1234]}, "R2 read mid", int'(d), int'(buf_m[1234]));
        rd(16'(BUF - 1), d); check(d == {8'h00, buf_m[BUF-1]}, "R2 read top", int'(d), int'(buf_m[BUF-1]));
        wr(16'd3000, 16'h00AA);
        rd(16'd3000, d); check(d == 0, "R2 out of range", int'(d), 0);

        // R3: send 20 bytes
        wr(16'h4010, 16'd20);
        send(20);
        wait_idle();
        check(tx_seen == 20, "R3 byte count", tx_seen, 20);
        check(tx_bad == 0, "R3 stream content", tx_bad, 0);

        // R3: length above the buffer clamps to BUF
        wr(16'h4010, 16'd5000);
        send(BUF);
        wait_idle();
        check(tx_seen == BUF, "R3 clamp count", tx_seen, BUF);
        check(tx_bad == 0, "R3 clamp content", tx_bad, 0);

        // R4: zero length sends nothing
        wr(16'h4010, 16'd0);
        send(0);
        rd(16'h4030, d); check(d == 0, "R4 busy", int'(d), 0);
        repeat (10) @(negedge clk);
        check(tx_seen == 0, "R4 no bytes", tx_seen, 0);

        // R10: unknown command value does nothing
        wr(16'h4010, 16'd4);
        exp_tx.delete(); tx_seen = 0; tx_bad = 0; tx_pos = 0;
        wr(16'h4020, 16'h0007);
        rd(16'h4030, d); check(d == 0, "R10 busy", int'(d), 0);
        repeat (10) @(negedge clk);
        check(tx_seen == 0, "R10 no bytes", tx_seen, 0);
        rd(16'h4000, d); check(d == 0, "R10 status", int'(d), 0);

        // R9: commands during a send are ignored
        rx_pkt(6, 8'h40);
        wr(16'h4010, 16'd100);
        send(100);
        rd(16'h4030, d); check(d == 1, "R9 busy set", int'(d), 1);
        wr(16'h4020, 16'h0001);
        wr(16'h4020, 16'h0000);
        wait_idle();
        check(tx_seen == 100, "R9 single send", tx_seen, 100);
        check(tx_bad == 0, "R9 stream content", tx_bad, 0);
        rd(16'h4000, d); check(d == 0, "R9 ignored recv status", int'(d), 0);

        // R6: three packets waiting, delivered in order
        rx_pkt(5, 8'h60);
        rx_pkt(7, 8'h80);
        recv(est, elen);
        check(irq == 1'b1, "R8 irq high", int'(irq), 1);
        rd(16'h4010, d); check(int'(d) == elen, "R6 length 1", int'(d), elen);
        rd(16'h4000, d); check(int'(d) == est, "R6 status more", int'(d), est);
        @(negedge clk);
        check(irq == 1'b0, "R8 irq cleared", int'(irq), 0);
        rd(16'h4000, d); check(d == 0, "R8 status cleared", int'(d), 0);
        rd(16'd0, d); check(d == {8'h00, buf_m[0]}, "R6 data first", int'(d), int'(buf_m[0]));
        rd(16'd5, d); check(d == {8'h00, buf_m[5]}, "R6 data last", int'(d), int'(buf_m[5]));
        recv(est, elen);
        rd(16'h4000, d); check(int'(d) == est, "R6 status 2", int'(d), est);
        recv(est, elen);
        rd(16'h4010, d); check(int'(d) == elen, "R6 length 3", int'(d), elen);
        rd(16'h4000, d); check(int'(d) == est && est == 1, "R6 last status", int'(d), 1);
        rd(16'd6, d); check(d == {8'h00, buf_m[6]}, "R6 data pkt3", int'(d), int'(buf_m[6]));

        // R7: empty receive
        recv(est, elen);
        check(irq == 1'b0, "R7 irq", int'(irq), 0);
        rd(16'h4000, d); check(d == 0, "R7 status", int'(d), 0);
        rd(16'h4010, d); check(d == 0, "R7 length", int'(d), 0);

        // R5: five packets, the fifth dropped
        for (int k = 0; k < 5; k++) rx_pkt(2 + k, 16 * k);
        for (int k = 0; k < 4; k++) begin
            recv(est, elen);
            rd(16'h4010, d); check(int'(d) == elen && elen == 2 + k, "R5 length", int'(d), 2 + k);
            rd(16'h4000, d); check(int'(d) == est, "R5 status", int'(d), est);
        end
        recv(est, elen);
        rd(16'h4000, d); check(d == 0, "R5 fifth dropped", int'(d), 0);

        // R11 and R12: oversize packet truncated, then a packet with no room dropped
        rx_pkt(BUF + 2, 8'h11);
        rx_pkt(5, 8'h22);
        recv(est, elen);
        rd(16'h4010, d); check(int'(d) == BUF, "R11 truncated length", int'(d), BUF);
        rd(16'h4000, d); check(d == 1, "R12 no more waiting", int'(d), 1);
        rd(16'(BUF - 1), d); check(d == {8'h00, buf_m[BUF-1]}, "R11 last byte", int'(d), int'(buf_m[BUF-1]));
        recv(est, elen);
        rd(16'h4000, d); check(d == 0, "R12 dropped packet absent", int'(d), 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule